// File: doc/BRIEF.md
# Floating-Point Tag Word Compressor and Expander

This block converts between the two forms a floating-point register stack's tag state takes in a processor's state save and restore path. The full form is a 16-bit word with a 2-bit tag for each of the eight stack registers. The abridged form is an 8-bit byte with one occupancy bit for each register. When saving, the block compresses the full word to the byte. It also merges the current stack-top pointer into the saved status word.

When restoring, the abridged byte says only whether each register holds something. For each occupied register, the block rebuilds the full 2-bit tag by looking at the 80-bit register image. It examines the 15-bit exponent and the explicit integer bit, which is bit 63 of the significand. It also takes the stack-top pointer back out of the restored status word.

A caller drives `start` high for one cycle and selects the direction with `expandMode`. Compression finishes in one cycle. Expansion handles one register per cycle, starting with register 0, and takes eight cycles. While the expansion runs, the caller must hold `regImages` steady. `done` then pulses for one cycle.

Top module: `fpuTagCodec`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `abridgedOut`, `statusOut`, `tagWordOut` and `topOut` are all 0.
- R2: In compress mode, register i's tag sits in `tagWordIn` bits 2i+1:2i. Bit i of `abridgedOut` is 0 when that tag is 11 (empty) and 1 for the tags 00 (valid), 01 (zero) and 10 (special).
- R3: In compress mode, `statusOut` bits 13:11 take the value of `topIn`. Every other bit of `statusOut` equals the same bit of `statusIn`.
- R4: If `start` is sampled with `expandMode`=0 while idle, `done` is 1 for exactly the next cycle and the compress results are valid in that cycle. `busy` stays 0.
- R5: In expand mode, a register whose bit in `abridgedIn` is 0 gets tag 11 in `tagWordOut`, at bits 2i+1:2i, whatever its image holds.
- R6: In expand mode, the image of register i is `regImages` bits 80i+79:80i. Within it, bits 63:0 are the significand, bits 78:64 the exponent and bit 79 the sign. An occupied register with exponent 0 gets tag 01 when its significand is all zero and tag 10 otherwise.
- R7: In expand mode, an occupied register with exponent 0x7FFF gets tag 10. An occupied register with any other non-zero exponent gets tag 00 when significand bit 63 is 1 and 10 when it is 0. The sign bit never affects the tag.
- R8: In expand mode, `topOut` becomes bits 13:11 of `statusIn` as sampled with `start`.
- R9: If `start` is sampled with `expandMode`=1 while idle, `busy` is 1 for the next 8 cycles. `done` is 1 only in the cycle after the eighth, and that single cycle carries the final `tagWordOut`.
- R10: Once `busy` is 0, `tagWordOut` and `topOut` keep their values until the next accepted expand start.
- R11: A `start` sampled while `busy` is 1 is ignored. It changes none of the outputs, and it neither shortens nor extends the running expansion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin an operation |
| expandMode | input | 1 | 0 selects compress, 1 selects expand |
| tagWordIn | input | 16 | Full tag word to compress |
| statusIn | input | 16 | Status word (saved in compress mode, restored in expand mode) |
| topIn | input | 3 | Current stack-top pointer for compress mode |
| abridgedIn | input | 8 | Abridged occupancy byte for expand mode |
| regImages | input | 640 | Eight 80-bit register images, register i at bits 80i+79:80i |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | One-cycle completion pulse |
| abridgedOut | output | 8 | Compressed occupancy byte |
| statusOut | output | 16 | Status word with the stack-top field inserted |
| tagWordOut | output | 16 | Rebuilt full tag word |
| topOut | output | 3 | Stack-top pointer recovered from the restored status word |

## Verification
The bound checker checks the cycle-level behaviour on every clock edge:

- Compressed bits match the tags they came from.
- The status word passes through with the stack-top field inserted.
- A start during a run has no effect.
- `done` is a single-cycle pulse.
- The tag word holds still while the block is idle.

The checker cannot show that each register class gets the right tag, or that expansion lasts exactly eight cycles. The bench's scenarios show these. They mix random register images with directed zeros, denormals, infinities, normal values and values whose integer bit is clear. They also count the cycles from start to `done`.

// File: rtl/fpuTagPkg.sv
package fpuTagPkg;
  parameter int NUM_REGS = 8;
  parameter int TAG_W    = 2;
  parameter int EXP_W    = 15;
  parameter int SIG_W    = 64;
  parameter int STAT_W   = 16;
  parameter int TOP_LSB  = 11;

  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int IMG_W    = SIG_W + EXP_W + 1;
  localparam int TAGWORD_W = NUM_REGS * TAG_W;
  localparam int IMGBUS_W = NUM_REGS * IMG_W;

  typedef enum logic [TAG_W-1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tagCode_e;

  typedef struct packed {
    logic             loadCompress;
    logic             loadExpand;
    logic             classifyEn;
    logic [IDX_W-1:0] idx;
  } ctrlStrobe_t;

  function automatic tagCode_e classifyImage(input logic [IMG_W-1:0] img);
    logic [EXP_W-1:0] expo;
    logic [SIG_W-1:0] sig;
    expo = img[SIG_W +: EXP_W];
    sig  = img[SIG_W-1:0];
    if (expo == '0)
      return (sig == '0) ? TAG_ZERO : TAG_SPECIAL;
    else if (expo == '1)
      return TAG_SPECIAL;
    else if (sig[SIG_W-1])
      return TAG_VALID;
    else
      return TAG_SPECIAL;
  endfunction
endpackage

// File: rtl/fpuTagCtrl.sv
module fpuTagCtrl
  import fpuTagPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        expandMode,
  output ctrlStrobe_t strobes,
  output logic        busy,
  output logic        done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic             busyQ;
  logic [IDX_W-1:0] idxQ;
  logic             accept;
  logic             lastStep;

  assign accept   = start && !busyQ;
  assign lastStep = busyQ && (idxQ == LAST_IDX);

  always_comb begin
    strobes.loadCompress = accept && !expandMode;
    strobes.loadExpand   = accept && expandMode;
    strobes.classifyEn   = busyQ;
    strobes.idx          = idxQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
      done  <= 1'b0;
    end else begin
      done <= (accept && !expandMode) || lastStep;
      if (accept && expandMode) begin
        busyQ <= 1'b1;
        idxQ  <= '0;
      end else if (busyQ) begin
        idxQ <= idxQ + 1'b1;
        if (lastStep) busyQ <= 1'b0;
      end
    end
  end

  assign busy = busyQ;
endmodule

// File: rtl/fpuTagPath.sv
module fpuTagPath
  import fpuTagPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobes,
  input  logic [TAGWORD_W-1:0]  tagWordIn,
  input  logic [STAT_W-1:0]     statusIn,
  input  logic [IDX_W-1:0]      topIn,
  input  logic [NUM_REGS-1:0]   abridgedIn,
  input  logic [IMGBUS_W-1:0]   regImages,
  output logic [NUM_REGS-1:0]   abridgedOut,
  output logic [STAT_W-1:0]     statusOut,
  output logic [TAGWORD_W-1:0]  tagWordOut,
  output logic [IDX_W-1:0]      topOut
);
  logic [NUM_REGS-1:0]  occupied;
  logic [NUM_REGS-1:0]  compressed;
  logic [STAT_W-1:0]    mergedStatus;
  logic [IMG_W-1:0]     curImage;
  tagCode_e             curTag;
  logic [NUM_REGS-1:0]  occQ;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_squeeze
    assign compressed[g] = (tagWordIn[g*TAG_W +: TAG_W] != TAG_EMPTY);
  end

  always_comb begin
    mergedStatus = statusIn;
    mergedStatus[TOP_LSB +: IDX_W] = topIn;
  end

  assign curImage = regImages[int'(strobes.idx) * IMG_W +: IMG_W];
  assign occupied = occQ;
  assign curTag   = occupied[strobes.idx] ? classifyImage(curImage) : TAG_EMPTY;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abridgedOut <= '0;
      statusOut   <= '0;
      topOut      <= '0;
      occQ        <= '0;
    end else begin
      if (strobes.loadCompress) begin
        abridgedOut <= compressed;
        statusOut   <= mergedStatus;
      end
      if (strobes.loadExpand) begin
        occQ   <= abridgedIn;
        topOut <= statusIn[TOP_LSB +: IDX_W];
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        tagWordOut[g*TAG_W +: TAG_W] <= '0;
      else if (strobes.classifyEn && (strobes.idx == IDX_W'(g)))
        tagWordOut[g*TAG_W +: TAG_W] <= curTag;
    end
  end
endmodule

// File: rtl/fpuTagCodec.sv
module fpuTagCodec
  import fpuTagPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          expandMode,
  input  logic [15:0]   tagWordIn,
  input  logic [15:0]   statusIn,
  input  logic [2:0]    topIn,
  input  logic [7:0]    abridgedIn,
  input  logic [639:0]  regImages,
  output logic          busy,
  output logic          done,
  output logic [7:0]    abridgedOut,
  output logic [15:0]   statusOut,
  output logic [15:0]   tagWordOut,
  output logic [2:0]    topOut
);
  ctrlStrobe_t strobes;

  fpuTagCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .expandMode(expandMode),
    .strobes(strobes), .busy(busy), .done(done)
  );

  fpuTagPath path_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .tagWordIn(tagWordIn), .statusIn(statusIn), .topIn(topIn),
    .abridgedIn(abridgedIn), .regImages(regImages),
    .abridgedOut(abridgedOut), .statusOut(statusOut),
    .tagWordOut(tagWordOut), .topOut(topOut)
  );
endmodule

// File: rtl/fpuTagCodecChecker.sv
module fpuTagCodecChecker (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         expandMode,
  input logic [15:0]  tagWordIn,
  input logic [15:0]  statusIn,
  input logic [2:0]   topIn,
  input logic         busy,
  input logic         done,
  input logic [7:0]   abridgedOut,
  input logic [15:0]  statusOut,
  input logic [15:0]  tagWordOut,
  input logic [2:0]   topOut
);
  logic takeCompress;
  logic takeExpand;
  assign takeCompress = start && !busy && !expandMode;
  assign takeExpand   = start && !busy && expandMode;

  for (genvar g = 0; g < 8; g++) begin : g_bits
    assert_abridged_bit_R2: assert property (@(posedge clk) disable iff (!rstN)
      takeCompress |=> abridgedOut[g] == ($past(tagWordIn[2*g +: 2]) != 2'b11));
  end

  assert_status_merge_R3: assert property (@(posedge clk) disable iff (!rstN)
    takeCompress |=> (statusOut[13:11] == $past(topIn)) &&
                     (statusOut[10:0] == $past(statusIn[10:0])) &&
                     (statusOut[15:14] == $past(statusIn[15:14])));

  assert_compress_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    takeCompress |=> done && !busy);

  assert_top_restore_R8: assert property (@(posedge clk) disable iff (!rstN)
    takeExpand |=> busy && (topOut == $past(statusIn[13:11])));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_hold_tags_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(tagWordOut) && $stable(topOut));

  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(abridgedOut) && $stable(statusOut) && $stable(topOut));
endmodule

bind fpuTagCodec fpuTagCodecChecker chk_i (
  .clk(clk), .rstN(rstN), .start(start), .expandMode(expandMode),
  .tagWordIn(tagWordIn), .statusIn(statusIn), .topIn(topIn),
  .busy(busy), .done(done), .abridgedOut(abridgedOut),
  .statusOut(statusOut), .tagWordOut(tagWordOut), .topOut(topOut)
);

// File: tb/fpuTagCodec_tb_top.sv
module fpuTagCodec_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         expandMode = 1'b0;
  logic [15:0]  tagWordIn = '0;
  logic [15:0]  statusIn = '0;
  logic [2:0]   topIn = '0;
  logic [7:0]   abridgedIn = '0;
  logic [639:0] regImages = '0;
  logic         busy, done;
  logic [7:0]   abridgedOut;
  logic [15:0]  statusOut, tagWordOut;
  logic [2:0]   topOut;

  int checkCount = 0;
  int failCount  = 0;

  always #10 clk = ~clk;

  fpuTagCodec dut_i (
    .clk(clk), .rstN(rstN), .start(start), .expandMode(expandMode),
    .tagWordIn(tagWordIn), .statusIn(statusIn), .topIn(topIn),
    .abridgedIn(abridgedIn), .regImages(regImages),
    .busy(busy), .done(done), .abridgedOut(abridgedOut),
    .statusOut(statusOut), .tagWordOut(tagWordOut), .topOut(topOut)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expSqueeze(input logic [15:0] tw);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = !(tw[2*i] && tw[2*i+1]);
    return r;
  endfunction

  function automatic logic [1:0] expTag(input bit occ, input logic [79:0] img);
    logic [14:0] e;
    e = img[78:64];
    if (!occ) return 2'b11;
    if (e == 15'h7FFF) return 2'b10;
    if (e == 15'h0000) return (img[63:0] == 64'd0) ? 2'b01 : 2'b10;
    return img[63] ? 2'b00 : 2'b10;
  endfunction

  function automatic logic [79:0] makeImage(input int kind);
    logic [79:0] im;
    im[79] = 1'($urandom);
    im[63:0] = {$urandom, $urandom};
    im[78:64] = 15'($urandom);
    case (kind)
      0: begin im[78:64] = '0; im[63:0] = '0; end
      1: begin im[78:64] = '0; im[0] = 1'b1; end
      2: im[78:64] = 15'h7FFF;
      3: begin if (im[78:64] == 0 || im[78:64] == 15'h7FFF) im[78:64] = 15'h3FFF; im[63] = 1'b1; end
      4: begin if (im[78:64] == 0 || im[78:64] == 15'h7FFF) im[78:64] = 15'h0001; im[63] = 1'b0; end
      default: ;
    endcase
    return im;
  endfunction

  task automatic doCompress(input logic [15:0] tw, input logic [15:0] st, input logic [2:0] tp);
    logic [15:0] expSt;
    @(negedge clk);
    tagWordIn = tw; statusIn = st; topIn = tp; expandMode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1 && busy == 1'b0, "R4 done one cycle after compress start", {busy, done}, 2'b01);
    check(abridgedOut == expSqueeze(tw), "R2 abridged byte", abridgedOut, expSqueeze(tw));
    expSt = st; expSt[13:11] = tp;
    check(statusOut == expSt, "R3 status merge", statusOut, expSt);
    @(negedge clk);
    check(done == 1'b0, "R4 done single pulse", done, 0);
  endtask

  task automatic doExpand(input logic [7:0] ab, input logic [15:0] st, input bit poke);
    logic [15:0] expTw;
    logic [7:0]  keepAb;
    logic [15:0] keepSt;
    bit          early;
    for (int i = 0; i < 8; i++) expTw[2*i +: 2] = expTag(ab[i], regImages[80*i +: 80]);
    keepAb = abridgedOut; keepSt = statusOut;
    @(negedge clk);
    abridgedIn = ab; statusIn = st; expandMode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; abridgedIn = ~ab; statusIn = ~st;
    early = 1'b0;
    for (int c = 1; c < 8; c++) begin
      if (poke && c == 3) begin
        expandMode = 1'b0; tagWordIn = ~tagWordIn; topIn = ~topIn; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (done || !busy) early = 1'b1;
    end
    @(negedge clk);
    check(!early && done && !busy, "R9 done exactly 8 cycles after expand start", {early, busy, done}, 3'b001);
    check(tagWordOut == expTw, "R5 R6 R7 rebuilt tag word", tagWordOut, expTw);
    check(topOut == st[13:11], "R8 stack top from status", topOut, st[13:11]);
    if (poke) begin
      check(abridgedOut == keepAb && statusOut == keepSt, "R11 start while busy ignored",
            {abridgedOut, statusOut}, {keepAb, keepSt});
    end
    @(negedge clk);
    check(done == 1'b0, "R9 done single pulse", done, 0);
    repeat (2) @(negedge clk);
    check(tagWordOut == expTw && topOut == st[13:11], "R10 results held while idle",
          {topOut, tagWordOut}, {st[13:11], expTw});
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failCount++;
    $display("FAIL R9 watchdog expired actual=hung expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && abridgedOut == 0 && statusOut == 0 &&
          tagWordOut == 0 && topOut == 0, "R1 reset state",
          {busy, done, abridgedOut, statusOut, tagWordOut, topOut}, 0);
    rstN = 1'b1;

    doCompress(16'hFFFF, 16'h0000, 3'd7);
    doCompress(16'h0000, 16'hFFFF, 3'd0);
    doCompress(16'h9C6B, 16'hA5A5, 3'd5);
    for (int n = 0; n < 30; n++)
      doCompress(16'($urandom), 16'($urandom), 3'($urandom));

    for (int i = 0; i < 8; i++) regImages[80*i +: 80] = makeImage(i % 6);
    doExpand(8'hFF, 16'h3800, 1'b0);
    doExpand(8'h00, 16'h0800, 1'b0);
    for (int i = 0; i < 8; i++) regImages[80*i +: 80] = makeImage(i < 5 ? i : 0);
    regImages[80*7 +: 80] = {1'b1, 15'h7FFE, 64'h8000_0000_0000_0000};
    doExpand(8'hFF, 16'hC7FF, 1'b1);
    for (int n = 0; n < 25; n++) begin
      for (int i = 0; i < 8; i++) regImages[80*i +: 80] = makeImage(int'($urandom % 6));
      doExpand(8'($urandom), 16'($urandom), n % 4 == 0);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule